// File: doc/BRIEF.md
# Binary64 Rounding and Packing Unit

This unit is the last stage of a double-precision arithmetic datapath. It accepts a result that has not yet been rounded and returns the final 64-bit encoding. The result arrives as a sign, a signed unbiased exponent, a normalized 53-bit significand whose top bit is the hidden one, and three extra bits below it (guard, round and sticky). A rounding mode arrives on its own pin with each transfer. The unit moves results into the subnormal range by shifting right, rounds under the selected mode, and handles a carry out of the significand. It picks infinity or the largest finite value on overflow and raises the inexact, overflow and underflow flags.

Data moves on a valid/ready stream with one register stage. An input is taken on a rising edge when `in_valid` and `in_ready` are both high. The packed result is on the output one cycle later. While `out_valid` is high and `out_ready` is low, the output word and flags stay frozen and `in_ready` is low. This back-pressure reaches the producer in the same cycle. When the consumer takes a result, the unit can accept a new input on that same edge. There is no bubble.

Top module: `f64_round_pack`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. An accepted input appears on the output after the next rising edge. While the output is stalled, `out_valid`, `out_word` and the flags hold.
- R2: The output word has the sign in bit 63, the biased exponent (unbiased + 1023) in bits 62..52 and the fraction in bits 51..0, with the hidden bit dropped. Input exponent 0 with significand 2^52 and zero extra bits gives 0x3FF0000000000000.
- R3: `in_mode` selects the rounding: 0 = nearest with ties to even, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity.
- R4: In nearest mode the unit keeps the 53 kept bits. It rounds up when the discarded part is above half an ulp, or exactly half with an odd last bit. Guard is the first discarded bit, round is the next, and sticky is the OR of all lower bits.
- R5: When the biased exponent is 0 or below, the significand and the extra bits are shifted right by (1 − biased exponent) before rounding. Shifted-out bits join sticky. The result has exponent field 0, or 1 if rounding reaches the hidden bit. A value too small for any subnormal rounds to zero or to the smallest subnormal, depending on the mode.
- R6: A rounding carry out of the 53-bit significand adds one to the exponent field and clears the fraction.
- R7: If the final exponent field would be 2047 or more, `out_overflow` and `out_inexact` are set. The word is infinity (field 2047, fraction 0) in nearest mode and in the directed mode that points the same way as the sign. In the other two cases it is the largest finite magnitude (field 2046, fraction all ones).
- R8: `out_inexact` is set exactly when rounding discarded a nonzero value, or on overflow.
- R9: `out_underflow` is set only when the biased exponent before rounding is below 1 and the result is inexact.
- R10: An input whose significand top bit is 0 is a zero. The output is a zero with the input sign, and all three flags are clear.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input transfer offered |
| in_ready | output | 1 | Unit can take an input this cycle |
| in_sign | input | 1 | Sign of the unrounded result |
| in_exp | input | 13 | Unbiased exponent, two's complement |
| in_sig | input | 53 | Significand, bit 52 is the hidden bit |
| in_grs | input | 3 | Guard (bit 2), round (bit 1), sticky (bit 0) |
| in_mode | input | 2 | Rounding mode, encoding per R3 |
| out_valid | output | 1 | Packed result available |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_word | output | 64 | Packed binary64 result |
| out_inexact | output | 1 | Rounding discarded nonzero bits or overflow |
| out_overflow | output | 1 | Result exceeded the finite range |
| out_underflow | output | 1 | Tiny and inexact result |

## Verification
The sweep walks every guard/round/sticky combination under all four modes and both signs. It uses significands that tell a tie from a half-up (even and odd last bits), an all-ones significand that forces a carry into the exponent, and a zero. These run over exponents that cover the whole subnormal band, including shifts past all kept bits, and the top of the normal range, where carries and overflow show whether each mode chooses infinity or the largest finite value. Two directed cases check the exact encoding of 1.0 and a stall, in which a held output must not change while a second input waits.

// File: rtl/f64rp_pkg.sv
package f64rp_pkg;
  localparam int FRAC_W = 52;
  localparam int EXP_W  = 11;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_POS  = 2'd2,
    RM_NEG  = 2'd3
  } rmode_t;

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;
  } f64_t;
endpackage

// File: rtl/f64rp_align.sv
// Moves a tiny result into subnormal position; shifted-out bits fold into sticky.
module f64rp_align #(
  parameter int SIG_W = 53,
  parameter int EW    = 14
) (
  input  logic signed [EW-1:0] bexp,
  input  logic [SIG_W-1:0]     sig,
  input  logic [2:0]           grs,
  output logic [SIG_W-1:0]     kept,
  output logic                 guard,
  output logic                 sticky,
  output logic                 tiny
);
  localparam int VW  = SIG_W + 3;
  localparam int SHW = $clog2(VW + 1) + 1;
  localparam logic signed [EW-1:0] VW_S = EW'(VW);
  localparam logic signed [EW-1:0] ONE_S = EW'(1);

  logic signed [EW-1:0] need;
  logic [SHW-1:0]       sh;
  logic [VW-1:0]        vec, shifted, lost_mask;
  logic                 lost;

  always_comb begin
    tiny = (bexp < ONE_S);
    need = ONE_S - bexp;
    if (!tiny)           sh = '0;
    else if (need > VW_S) sh = SHW'(VW);
    else                 sh = need[SHW-1:0];
    vec       = {sig, grs};
    shifted   = vec >> sh;
    lost_mask = ~({VW{1'b1}} << sh);
    lost      = |(vec & lost_mask);
    kept      = shifted[VW-1:3];
    guard     = shifted[2];
    sticky    = shifted[1] | shifted[0] | lost;
  end
endmodule

// File: rtl/f64rp_incr.sv
// Decides the rounding increment and applies it to the kept significand.
module f64rp_incr #(
  parameter int SIG_W = 53
) (
  input  logic [SIG_W-1:0]     kept,
  input  logic                 guard,
  input  logic                 sticky,
  input  logic                 sign,
  input  f64rp_pkg::rmode_t    mode,
  output logic [SIG_W:0]       sum,
  output logic                 inexact
);
  import f64rp_pkg::*;
  logic inc;

  always_comb begin
    inexact = guard | sticky;
    unique case (mode)
      RM_NEAR: inc = guard & (sticky | kept[0]);
      RM_ZERO: inc = 1'b0;
      RM_POS:  inc = inexact & ~sign;
      RM_NEG:  inc = inexact & sign;
      default: inc = 1'b0;
    endcase
    sum = {1'b0, kept} + (SIG_W + 1)'(inc);
  end
endmodule

// File: rtl/f64rp_pack.sv
// Forms the exponent field, resolves overflow by mode and builds the flags.
module f64rp_pack #(
  parameter int EW = 14
) (
  input  logic                          sign,
  input  logic                          tiny,
  input  logic                          is_zero,
  input  logic signed [EW-1:0]          bexp,
  input  logic [f64rp_pkg::SIG_W:0]     sum,
  input  f64rp_pkg::rmode_t             mode,
  input  logic                          rnd_inexact,
  output f64rp_pkg::f64_t               word,
  output logic                          ovf,
  output logic                          inx,
  output logic                          unf
);
  import f64rp_pkg::*;
  localparam logic signed [EW-1:0] EINF = EW'((1 << EXP_W) - 1);

  logic signed [EW-1:0] efield;
  logic                 to_inf;

  always_comb begin
    if (tiny) efield = EW'(sum[SIG_W-1]);
    else      efield = bexp + EW'(sum[SIG_W]);
    ovf    = !is_zero && (efield >= EINF);
    to_inf = (mode == RM_NEAR) || (mode == RM_POS && !sign) || (mode == RM_NEG && sign);
    inx    = !is_zero && (rnd_inexact || ovf);
    unf    = !is_zero && tiny && rnd_inexact;
    word.sign = sign;
    if (is_zero) begin
      word.expo = '0;
      word.frac = '0;
    end else if (ovf) begin
      word.expo = to_inf ? {EXP_W{1'b1}} : {{(EXP_W-1){1'b1}}, 1'b0};
      word.frac = to_inf ? '0 : {FRAC_W{1'b1}};
    end else begin
      word.expo = efield[EXP_W-1:0];
      word.frac = sum[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/f64_round_pack.sv
module f64_round_pack #(
  parameter int IN_EXP_W = 13
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic                        in_sign,
  input  logic signed [IN_EXP_W-1:0]  in_exp,
  input  logic [52:0]                 in_sig,
  input  logic [2:0]                  in_grs,
  input  logic [1:0]                  in_mode,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [63:0]                 out_word,
  output logic                        out_inexact,
  output logic                        out_overflow,
  output logic                        out_underflow
);
  import f64rp_pkg::*;
  localparam int EW = IN_EXP_W + 1;

  logic signed [EW-1:0] bexp;
  logic [SIG_W-1:0]     kept;
  logic                 guard, sticky, tiny, rnd_inexact;
  logic [SIG_W:0]       sum;
  f64_t                 word_c;
  logic                 ovf_c, inx_c, unf_c;
  rmode_t               mode;

  assign bexp     = EW'(in_exp) + EW'(BIAS);
  assign mode     = rmode_t'(in_mode);
  assign in_ready = !out_valid || out_ready;

  f64rp_align #(.SIG_W(SIG_W), .EW(EW)) u_align (
    .bexp(bexp), .sig(in_sig), .grs(in_grs),
    .kept(kept), .guard(guard), .sticky(sticky), .tiny(tiny)
  );

  f64rp_incr #(.SIG_W(SIG_W)) u_incr (
    .kept(kept), .guard(guard), .sticky(sticky), .sign(in_sign),
    .mode(mode), .sum(sum), .inexact(rnd_inexact)
  );

  f64rp_pack #(.EW(EW)) u_pack (
    .sign(in_sign), .tiny(tiny), .is_zero(!in_sig[SIG_W-1]), .bexp(bexp),
    .sum(sum), .mode(mode), .rnd_inexact(rnd_inexact),
    .word(word_c), .ovf(ovf_c), .inx(inx_c), .unf(unf_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_word      <= '0;
      out_inexact   <= 1'b0;
      out_overflow  <= 1'b0;
      out_underflow <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word      <= word_c;
        out_inexact   <= inx_c;
        out_overflow  <= ovf_c;
        out_underflow <= unf_c;
      end
    end
  end
endmodule

// File: rtl/f64rp_checks.sv
module f64rp_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_word,
  input logic        out_inexact,
  input logic        out_overflow,
  input logic        out_underflow
);
  assert_stall_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_inexact)));

  assert_drain_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_unf_inexact_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_underflow) |-> out_inexact);

  assert_ovf_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_overflow) |-> (out_inexact && out_word[62:53] == 10'h3FF));

  assert_no_nan_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_word[62:52] == 11'h7FF) |-> (out_word[51:0] == 52'd0 && out_overflow));

  assert_zero_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_word[62:0] == 63'd0) |-> !out_overflow);
endmodule

bind f64_round_pack f64rp_checks u_chk (.*);

// File: tb/tb_f64_round_pack.sv
module tb_f64_round_pack;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid;
  logic in_sign = 1'b0;
  logic signed [12:0] in_exp = '0;
  logic [52:0] in_sig = '0;
  logic [2:0] in_grs = '0;
  logic [1:0] in_mode = '0;
  logic [63:0] out_word;
  logic out_inexact, out_overflow, out_underflow;

  int checks = 0, errors = 0;

  f64_round_pack dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [63:0] word;
    logic inx, ovf, unf;
    string tag;
  } exp_t;

  // Reference: integer quotient/remainder against the ulp of the target position.
  function automatic exp_t model(logic s, int e, logic [52:0] sig, logic [2:0] grs, int md);
    exp_t r;
    longint m, q, rem, half, rr;
    int d, field;
    logic gt, eq, inx, up;
    r.inx = 0; r.ovf = 0; r.unf = 0;
    if (!sig[52]) begin
      r.word = {s, 63'd0}; r.tag = "R10"; return r;
    end
    m = (longint'(sig) << 3) | longint'(grs);
    d = (e >= -1022) ? 3 : 3 + (-1022 - e);
    if (d >= 60) begin
      q = 0; gt = 0; eq = 0; inx = 1;
    end else begin
      q = m >>> d;
      rem = m & ((64'sd1 <<< d) - 1);
      half = 64'sd1 <<< (d - 1);
      gt = rem > half; eq = rem == half; inx = rem != 0;
    end
    case (md)
      0: up = gt || (eq && q[0]);
      1: up = 0;
      2: up = inx && !s;
      default: up = inx && s;
    endcase
    rr = q + (up ? 1 : 0);
    r.tag = (md == 0) ? "R4" : "R3";
    if (e < -1022) begin
      r.tag = "R5";
      if (rr >= (64'sd1 <<< 52)) begin field = 1; rr = rr - (64'sd1 <<< 52); end
      else field = 0;
    end else begin
      field = e + 1023;
      if (rr == (64'sd1 <<< 53)) begin field = field + 1; rr = 0; r.tag = "R6"; end
      else rr = rr - (64'sd1 <<< 52);
    end
    r.inx = inx;
    r.unf = (e < -1022) && inx;
    if (field >= 2047) begin
      r.ovf = 1; r.inx = 1; r.tag = "R7";
      if (md == 0 || (md == 2 && !s) || (md == 3 && s)) r.word = {s, 11'h7FF, 52'd0};
      else r.word = {s, 11'h7FE, {52{1'b1}}};
    end else begin
      r.word = {s, 11'(field), rr[51:0]};
    end
    return r;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic check_out(exp_t x);
    chk(out_valid === 1'b1, "R1", 64'(out_valid), 64'd1);
    chk(out_word === x.word, x.tag, out_word, x.word);
    chk(out_inexact === x.inx, "R8", 64'(out_inexact), 64'(x.inx));
    chk(out_overflow === x.ovf, "R7", 64'(out_overflow), 64'(x.ovf));
    chk(out_underflow === x.unf, "R9", 64'(out_underflow), 64'(x.unf));
  endtask

  task automatic drive(logic s, int e, logic [52:0] sig, logic [2:0] grs, int md);
    in_valid = 1; in_sign = s; in_exp = 13'(e); in_sig = sig; in_grs = grs; in_mode = 2'(md);
  endtask

  initial begin
    repeat (CLK_PERIOD * 200000) #1;
    errors++; checks++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    exp_t pend, xa, xb;
    bit have;
    logic [52:0] sigs[5];
    int exps[$];
    sigs[0] = {1'b1, 52'd0};
    sigs[1] = {53{1'b1}};
    sigs[2] = {1'b1, 51'd0, 1'b1};
    sigs[3] = {1'b1, {26{2'b01}}};
    sigs[4] = 53'd0;
    for (int e = -1100; e <= -1015; e++) exps.push_back(e);
    for (int e = 1020; e <= 1024; e++) exps.push_back(e);
    exps.push_back(-4096); exps.push_back(4095); exps.push_back(0);

    repeat (3) @(negedge clk);
    // R11: reset state
    chk(out_valid === 1'b0, "R11", 64'(out_valid), 64'd0);
    chk(in_ready === 1'b1, "R11", 64'(in_ready), 64'd1);
    rst_n = 1;
    @(negedge clk);

    // R2: 1.0 encodes as 0x3FF0000000000000
    drive(0, 0, {1'b1, 52'd0}, 3'b000, 0);
    @(negedge clk);
    in_valid = 0;
    chk(out_word === 64'h3FF0000000000000, "R2", out_word, 64'h3FF0000000000000);

    // Sweep: one transfer per cycle, result checked one cycle later
    have = 0;
    foreach (exps[i]) begin
      for (int si = 0; si < 5; si++) begin
        for (int g = 0; g < 8; g++) begin
          for (int md = 0; md < 4; md++) begin
            for (int s = 0; s < 2; s++) begin
              @(negedge clk);
              if (have) check_out(pend);
              drive(1'(s), exps[i], sigs[si], 3'(g), md);
              pend = model(1'(s), exps[i], sigs[si], 3'(g), md);
              have = 1;
            end
          end
        end
      end
    end
    @(negedge clk);
    in_valid = 0;
    check_out(pend);
    @(negedge clk);
    chk(out_valid === 1'b0, "R1", 64'(out_valid), 64'd0);

    // R1: stall with a second input waiting
    out_ready = 0;
    drive(1, 5, sigs[2], 3'b110, 2);
    xa = model(1, 5, sigs[2], 3'b110, 2);
    @(negedge clk);
    drive(0, -1060, sigs[1], 3'b101, 0);
    xb = model(0, -1060, sigs[1], 3'b101, 0);
    chk(in_ready === 1'b0, "R1", 64'(in_ready), 64'd0);
    repeat (2) @(negedge clk);
    chk(out_word === xa.word, "R1", out_word, xa.word);
    chk(in_ready === 1'b0, "R1", 64'(in_ready), 64'd0);
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    check_out(xb);
    @(negedge clk);
    chk(out_valid === 1'b0, "R1", 64'(out_valid), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule